// File: doc/BRIEF.md
# Host Parallel Slave Port

This block connects an external host processor to a local microcontroller through an asynchronous parallel bus. The bus has an 8-bit data path, one address line, an active-low chip select and separate active-low read and write strobes. The host strobes are brought into the local clock domain through synchronisers. Bytes then pass through a 16-entry byte FIFO. Its direction is set by the local CPU. With direction 0, the host fills the FIFO and the CPU drains it. With direction 1, the CPU fills it and the host drains it.

The local CPU reaches the block through a small synchronous register port with four registers: control, status, data and host status. The host reads the host status register when the address line is high, and the FIFO when it is low. An interrupt request goes to the CPU from the FIFO conditions, each gated by its own mask bit. While the enable bit is clear, the block ignores host traffic, does not drive the data pins, holds the FIFO empty and keeps its flags cleared.

Top module: `host_bus_slave`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x01 (FIFO empty only), irq_o is 0 and host_d_oe_o is 0. Local register addresses: 0 control, 1 status, 2 data, 3 host status.
- R2: While control bit 0 (enable) is 0, host writes add nothing to the FIFO, writes to the data register add nothing, and host reads do not drive host_d_oe_o.
- R3: With enable set and control bit 1 (direction) at 0, every completed host write with address 0 appends its byte to the FIFO. Each local read of the data register returns the oldest byte and removes it.
- R4: With direction 1, each local write of the data register appends a byte. A host read with address 0 drives the oldest byte on host_d_o, with host_d_oe_o high only while chip select and read are both low. The byte is removed when the read strobe ends.
- R5: A host read with address 1 returns the host status {5'b0, ready, full, empty}, with ready at bit 2, full at bit 1 and empty at bit 0, and removes nothing. A host write with address 1 has no effect. The local CPU sets ready through bit 2 of register 3.
- R6: The FIFO holds 16 bytes. Status bit 1 (full) is set at 16 entries and status bit 2 (half) is set at 8 or more entries. Status bit 0 is empty.
- R7: A host write to a full FIFO is dropped and sets sticky status bit 3 (overflow). Writing a 1 to status bit 3 clears it, and writing 0 leaves it set.
- R8: irq_o is the OR of status bits 0..3, each ANDed with control bits 4..7 in the same order. It is 0 while the block is disabled.
- R9: Clearing enable empties the FIFO and clears overflow and ready.
- R10: When a host-write push and a local data read land in the same clock, both take effect. The stored order and the count stay exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_a0_i | input | 1 | Host address line: 0 FIFO, 1 host status |
| host_d_i | input | 8 | Host write data |
| host_d_o | output | 8 | Host read data |
| host_d_oe_o | output | 1 | Drive enable for the host data pins |
| reg_addr_i | input | 2 | Local register select |
| reg_wr_i | input | 1 | Local register write |
| reg_rd_i | input | 1 | Local register read (pops on the data register) |
| reg_wdata_i | input | 8 | Local write data |
| reg_rdata_o | output | 8 | Local read data |
| irq_o | output | 1 | Interrupt request to the local CPU |

## Verification
The host-write push and a local data-register pop can commit on the same clock edge, because the push arrives late through the strobe synchroniser. The bench keeps the FIFO partly filled and releases a host write strobe. It then issues a single local data read at each offset from zero to four cycles after the release, so one of those offsets lands on the push edge. A scoreboard queue holds the bytes in expected order. The FIFO is drained at the end to confirm that no byte was lost or duplicated and that empty rises exactly when the queue runs out.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STAT  = 2'd1,
    REG_DATA  = 2'd2,
    REG_HSTAT = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_DIR  = 1;
  localparam int unsigned STAT_OVF  = 3;
  localparam int unsigned HST_READY = 2;
  localparam logic [7:0]  CTRL_MASK = 8'hF3;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned DW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          a0_i,
  input  logic [DW-1:0] d_i,
  output logic          wr_evt_o,
  output logic          wr_a0_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_evt_o,
  output logic          rd_a0_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  assign raw = {cs_ni, rd_ni, wr_ni};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[i]};
    end
    assign synced[i] = chain[STAGES-1];
  end

  logic wr_act, rd_act, wr_act_q, rd_act_q;
  assign wr_act = ~synced[2] & ~synced[0];
  assign rd_act = ~synced[2] & ~synced[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      wr_a0_o   <= 1'b0;
      wr_data_o <= '0;
      rd_a0_o   <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      // pins are stable while the strobe is held low
      if (wr_act) begin
        wr_a0_o   <= a0_i;
        wr_data_o <= d_i;
      end
      if (rd_act) rd_a0_o <= a0_i;
    end
  end

  assign wr_evt_o = wr_act_q & ~wr_act;
  assign rd_evt_o = rd_act_q & ~rd_act;

  a_r3_single_wr_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_o |=> !wr_evt_o);
  a_r4_single_rd_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_o |=> !rd_evt_o);
endmodule

// File: rtl/hbs_fifo.sv
module hbs_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_CNT);
  assign half_o  = (count >= HALF_CNT);
  assign head_o  = empty_o ? '0 : mem[rd_ptr];

  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r3_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o && !flush_i) |=> count == $past(count) + 1'b1);
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
  a_r10_push_pop_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !flush_i) |=> $stable(count));
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/hbs_csr.sv
module hbs_csr
  import hbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic [7:0] head_i,
  input  logic       empty_i,
  input  logic       full_i,
  input  logic       half_i,
  input  logic       ovf_evt_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] hstat_o,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  logic       ovf_q, ready_q, en, ovf_clr;
  logic [3:0] flags;
  logic [7:0] stat;

  assign en      = ctrl_o[CTRL_EN];
  assign ovf_clr = reg_wr_i && (reg_addr_i == REG_STAT) && reg_wdata_i[STAT_OVF];
  assign flags   = {ovf_q, half_i, full_i, empty_i};
  assign stat    = {4'b0, flags};
  assign hstat_o = {5'b0, ready_q, full_i, empty_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      ovf_q   <= 1'b0;
      ready_q <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (reg_wr_i && reg_addr_i == REG_CTRL) ctrl_o <= reg_wdata_i & CTRL_MASK;
      if (!en) begin
        ovf_q   <= 1'b0;
        ready_q <= 1'b0;
      end else begin
        if (ovf_evt_i)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
        if (reg_wr_i && reg_addr_i == REG_HSTAT) ready_q <= reg_wdata_i[HST_READY];
      end
      irq_o <= en & |(flags & ctrl_o[7:4]);
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: rdata_o = ctrl_o;
      REG_STAT: rdata_o = stat;
      REG_DATA: rdata_o = head_i;
      default:  rdata_o = hstat_o;
    endcase
  end

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && en && !ovf_clr && !(reg_wr_i && reg_addr_i == REG_CTRL)) |=> ovf_q);
  a_r7_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_i && en && !(reg_wr_i && reg_addr_i == REG_CTRL)) |=> ovf_q);
  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !irq_o);
  a_r9_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (!ovf_q && !ready_q));
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave
  import hbs_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_cs_ni,
  input  logic       host_rd_ni,
  input  logic       host_wr_ni,
  input  logic       host_a0_i,
  input  logic [7:0] host_d_i,
  output logic [7:0] host_d_o,
  output logic       host_d_oe_o,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  logic       wr_evt, wr_a0, rd_evt, rd_a0;
  logic [7:0] wr_data, head, ctrl, hstat, push_data;
  logic       empty, full, half, push, pop, en, dir, host_push;

  hbs_sync #(.STAGES(SYNC_STAGES), .DW(8)) i_sync (
    .clk_i, .rst_ni,
    .cs_ni(host_cs_ni), .rd_ni(host_rd_ni), .wr_ni(host_wr_ni),
    .a0_i(host_a0_i), .d_i(host_d_i),
    .wr_evt_o(wr_evt), .wr_a0_o(wr_a0), .wr_data_o(wr_data),
    .rd_evt_o(rd_evt), .rd_a0_o(rd_a0)
  );

  assign en        = ctrl[CTRL_EN];
  assign dir       = ctrl[CTRL_DIR];
  assign host_push = en & ~dir & wr_evt & ~wr_a0;
  assign push      = dir ? (en & reg_wr_i & (reg_addr_i == REG_DATA)) : host_push;
  assign push_data = dir ? reg_wdata_i : wr_data;
  assign pop       = en & (dir ? (rd_evt & ~rd_a0) : (reg_rd_i & (reg_addr_i == REG_DATA)));

  hbs_fifo #(.DEPTH(DEPTH), .DW(8)) i_fifo (
    .clk_i, .rst_ni,
    .flush_i(~en), .push_i(push), .push_data_i(push_data), .pop_i(pop),
    .head_o(head), .empty_o(empty), .full_o(full), .half_o(half)
  );

  hbs_csr i_csr (
    .clk_i, .rst_ni,
    .reg_addr_i, .reg_wr_i, .reg_wdata_i,
    .head_i(head), .empty_i(empty), .full_i(full), .half_i(half),
    .ovf_evt_i(host_push & full),
    .ctrl_o(ctrl), .hstat_o(hstat), .rdata_o(reg_rdata_o), .irq_o
  );

  assign host_d_o    = host_a0_i ? hstat : head;
  assign host_d_oe_o = en & ~host_cs_ni & ~host_rd_ni;

  a_r5_status_read_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && rd_a0 && !(reg_rd_i && reg_addr_i == REG_DATA) && !reg_wr_i) |=> $stable(empty));
endmodule

// File: tb/test_host_bus_slave.sv
`timescale 1ns/1ps
module test_host_bus_slave;
  logic       clk = 0, rst_ni = 0;
  logic       cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0;
  logic [7:0] hd_i = 0, hd_o;
  logic       hd_oe;
  logic [1:0] raddr = 0;
  logic       rwr = 0, rrd = 0;
  logic [7:0] rwdata = 0, rrdata;
  logic       irq;

  int errors = 0, checks = 0;
  bit done = 0;
  byte unsigned exp_q[$];

  always #4 clk = ~clk;

  host_bus_slave i_host_bus_slave (
    .clk_i(clk), .rst_ni,
    .host_cs_ni(cs_n), .host_rd_ni(rd_n), .host_wr_ni(wr_n), .host_a0_i(a0),
    .host_d_i(hd_i), .host_d_o(hd_o), .host_d_oe_o(hd_oe),
    .reg_addr_i(raddr), .reg_wr_i(rwr), .reg_rd_i(rrd),
    .reg_wdata_i(rwdata), .reg_rdata_o(rrdata), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d, bit exp_push = 0);
    @(negedge clk); raddr = a; rwdata = d; rwr = 1;
    if (exp_push) exp_q.push_back(d);
    @(negedge clk); rwr = 0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); raddr = a; rrd = 0;
    #1 d = rrdata;
  endtask

  // monitor side: pop one byte and compare with scoreboard
  task automatic cpu_pop(string req);
    byte unsigned e;
    @(negedge clk); raddr = 2'd2; rrd = 1;
    #1;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
    chk(req, rrdata, e);
    @(negedge clk); rrd = 0;
  endtask

  task automatic host_write(logic addr, logic [7:0] d, bit exp_push);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = addr; hd_i = d;
    if (exp_push) exp_q.push_back(d);
    repeat (4) @(negedge clk);
    wr_n = 1; cs_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_read(logic addr, string req, int exp_val, bit from_q);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = addr;
    repeat (3) @(negedge clk);
    #1;
    chk({req, " oe"}, hd_oe, 1);
    if (from_q) exp_val = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
    chk(req, hd_o, exp_val);
    @(negedge clk); rd_n = 1; cs_n = 1;
    #1 chk({req, " oe off"}, hd_oe, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    reg_read(2'd0, d); chk("R1 ctrl", d, 8'h00);
    reg_read(2'd1, d); chk("R1 stat", d, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 oe", hd_oe, 0);

    // R2 disabled: host write ignored, cpu data write ignored, no drive
    host_write(0, 8'h5A, 0);
    reg_write(2'd2, 8'h11);
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = 0;
    repeat (3) @(negedge clk);
    #1 chk("R2 oe while disabled", hd_oe, 0);
    rd_n = 1; cs_n = 1;
    repeat (4) @(negedge clk);
    reg_write(2'd0, 8'h01);
    reg_read(2'd1, d); chk("R2 fifo stays empty", d, 8'h01);

    // R3 host-to-cpu ordering
    host_write(0, 8'hA1, 1);
    host_write(0, 8'hB2, 1);
    host_write(0, 8'hC3, 1);
    reg_read(2'd1, d); chk("R3 not empty", d, 8'h00);
    cpu_pop("R3 data0"); cpu_pop("R3 data1"); cpu_pop("R3 data2");
    reg_read(2'd1, d); chk("R3 empty after drain", d, 8'h01);

    // R5 host status read, host write at address 1 ignored
    host_write(1, 8'hEE, 0);
    reg_read(2'd1, d); chk("R5 write a1 ignored", d, 8'h01);
    reg_write(2'd3, 8'h04);
    host_write(0, 8'h77, 1);
    host_read(1, "R5 hstat", 8'h04, 0);
    cpu_pop("R5 no pop by status read");

    // R6 half/full thresholds and R7 overflow
    for (int i = 0; i < 7; i++) host_write(0, 8'(8'h10 + i), 1);
    reg_read(2'd1, d); chk("R6 seven entries", d, 8'h00);
    host_write(0, 8'h17, 1);
    reg_read(2'd1, d); chk("R6 half at eight", d, 8'h04);
    for (int i = 8; i < 16; i++) host_write(0, 8'(8'h10 + i), 1);
    reg_read(2'd1, d); chk("R6 full", d, 8'h06);
    reg_read(2'd3, d); chk("R5 hstat full", d, 8'h06);
    host_write(0, 8'hFF, 0);
    reg_read(2'd1, d); chk("R7 overflow set", d, 8'h0E);
    reg_write(2'd0, 8'h81); repeat (2) @(negedge clk);
    chk("R8 irq on overflow", irq, 1);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, d); chk("R7 write 0 keeps", d, 8'h0E);
    reg_write(2'd1, 8'h08);
    reg_read(2'd1, d); chk("R7 w1c", d, 8'h06);
    repeat (2) @(negedge clk);
    chk("R8 irq drops", irq, 0);
    for (int i = 0; i < 16; i++) cpu_pop("R7 drained data");
    reg_read(2'd1, d); chk("R7 dropped byte absent", d, 8'h01);

    // R8 mask per condition
    reg_write(2'd0, 8'h11); repeat (2) @(negedge clk);
    chk("R8 empty irq", irq, 1);
    reg_write(2'd0, 8'h21); repeat (2) @(negedge clk);
    chk("R8 full masked", irq, 0);
    reg_write(2'd0, 8'h10); repeat (2) @(negedge clk);
    chk("R8 quiet when disabled", irq, 0);

    // R4 cpu-to-host
    reg_write(2'd0, 8'h03);
    reg_write(2'd2, 8'h3C, 1);
    reg_write(2'd2, 8'h4D, 1);
    reg_write(2'd2, 8'h5E, 1);
    host_read(0, "R4 host data0", 0, 1);
    host_read(0, "R4 host data1", 0, 1);
    host_read(0, "R4 host data2", 0, 1);
    reg_read(2'd1, d); chk("R4 empty after host reads", d, 8'h01);

    // R9 disable flushes
    reg_write(2'd2, 8'h99);
    reg_write(2'd3, 8'h04);
    reg_write(2'd0, 8'h00);
    reg_write(2'd0, 8'h01);
    reg_read(2'd1, d); chk("R9 flushed", d, 8'h01);
    reg_read(2'd3, d); chk("R9 ready cleared", d, 8'h01);

    // R10 host push and cpu pop near/at the same edge
    host_write(0, 8'h80, 1);
    host_write(0, 8'h81, 1);
    for (int off = 0; off < 5; off++) begin
      @(negedge clk); cs_n = 0; wr_n = 0; a0 = 0; hd_i = 8'(8'h90 + off);
      exp_q.push_back(8'(8'h90 + off));
      repeat (4) @(negedge clk);
      wr_n = 1; cs_n = 1;
      repeat (off) @(negedge clk);
      raddr = 2'd2; rrd = 1;
      #1 chk("R10 pop vs push", rrdata, exp_q.pop_front());
      @(negedge clk); rrd = 0;
      repeat (5) @(negedge clk);
    end
    cpu_pop("R10 tail0");
    reg_read(2'd1, d); chk("R10 one left", d, 8'h00);
    cpu_pop("R10 tail1");
    reg_read(2'd1, d); chk("R10 count exact", d, 8'h01);
    chk("R10 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule